// File: doc/BRIEF.md
# Serial 24-bit command frame receiver

This block receives write-only commands from a 3-wire serial master. The master pulls an active-low select low, toggles a serial clock and presents one data bit per clock. The block takes each bit on a falling serial-clock edge, most significant bit first. After exactly 24 bits it splits the frame into an 8-bit command and a 16-bit data word. It hands both to the register logic that follows, together with a strobe one system clock long.

The serial clock, the select and the data pass through two-flop synchronisers. All edges are detected in the system clock domain, which must run at least four times faster than the serial clock. Extra clocks beyond the 24th have no effect. A select period that ends before 24 clocks produces nothing. Command decoding and readback are left to other blocks.

Top module: `spi_frame_rx`

## Requirements
- R1: While reset is asserted, and after it until the first accepted frame, `valid_o` is 0, `cmd_o` is 0x00 and `data_o` is 0x0000.
- R2: Bits are taken on falling serial-clock edges, most significant first. The first 8 bits of a frame form `cmd_o` (first bit at bit 7), and the next 16 form `data_o` (first of them at bit 15).
- R3: Each accepted frame raises `valid_o` for exactly one system clock cycle. The pulse comes no later than 4 system clock cycles after the 24th falling serial-clock edge.
- R4: If more than 24 falling edges arrive while the select is low, the frame is accepted once, at the 24th edge, and the later bits change nothing.
- R5: If the select rises before the 24th falling edge, no strobe is produced and `cmd_o`/`data_o` keep their values.
- R6: Serial-clock edges while the select is high are ignored. They add no bits to the next frame.
- R7: A frame begins only on a high-to-low select transition. That transition clears the bit count, so a partial frame followed by a new select-low period yields only the new frame.
- R8: `cmd_o` and `data_o` change only in the cycle in which `valid_o` is 1, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master (asynchronous) |
| cs_ni | input | 1 | Active-low frame select (asynchronous) |
| sdi_i | input | 1 | Serial data, sampled on falling serial-clock edges |
| cmd_o | output | 8 | Command byte of the last accepted frame |
| data_o | output | 16 | Data word of the last accepted frame |
| valid_o | output | 1 | One-cycle strobe per accepted frame |

## Verification
Several properties are checked on every cycle:
- the strobe never lasts more than one cycle;
- the outputs change only with the strobe;
- a strobe occurs only while the select is low, with the bit count at exactly 24;
- a select falling edge always clears the count.

Other behaviours need the bench's scenarios: the bit order and field split, a single acceptance for over-long frames, the silent discard of short frames, and immunity to clocks while the select is high. A behavioural model in the bench predicts the strobe and outputs, and it is compared against the design on every system clock.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // Reset levels of the synchronised serial pins
  localparam logic SCLK_IDLE = 1'b0;
  localparam logic CSN_IDLE  = 1'b1;
  localparam logic SDI_IDLE  = 1'b0;

  typedef struct packed {
    logic sclk;
    logic csn;
    logic sdi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sclk: SCLK_IDLE, csn: CSN_IDLE, sdi: SDI_IDLE};
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge
  import sfr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic csn_s_i,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_act_o
);
  logic sclk_q, csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= SCLK_IDLE;
      csn_q  <= CSN_IDLE;
    end else begin
      sclk_q <= sclk_s_i;
      csn_q  <= csn_s_i;
    end
  end

  assign sclk_fall_o = sclk_q & ~sclk_s_i;
  assign cs_fall_o   = csn_q & ~csn_s_i;
  assign cs_act_o    = ~csn_s_i;
endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  localparam int FRAME_W = CMD_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_fall_i,
  input  logic              cs_fall_i,
  input  logic              cs_act_i,
  input  logic              sdi_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic               armed_q, armed_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               valid_q, valid_d;
  logic               reg_en;

  // Next-state logic
  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    cmd_d   = cmd_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (!cs_act_i) begin
      armed_d = 1'b0;
    end else if (cs_fall_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && sclk_fall_i) begin
      sh_d  = {sh_q[FRAME_W-2:0], sdi_i};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) begin
        armed_d           = 1'b0;
        valid_d           = 1'b1;
        {cmd_d, data_d}   = sh_d;
      end
    end
  end

  // Clock enable for the shift and count registers
  assign reg_en = cs_fall_i | (armed_q & sclk_fall_i & cs_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (reg_en) begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else if (valid_d) begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  assign cmd_o   = cmd_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import sfr_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  pins_t            pins_raw, pins_s;
  logic             sclk_fall, cs_fall, cs_act;
  logic [CNT_W-1:0] bit_cnt;

  assign pins_raw = '{sclk: sclk_i, csn: cs_ni, sdi: sdi_i};

  sfr_sync #(
    .WIDTH  ($bits(pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  sfr_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (pins_s.sclk),
    .csn_s_i    (pins_s.csn),
    .sclk_fall_o(sclk_fall),
    .cs_fall_o  (cs_fall),
    .cs_act_o   (cs_act)
  );

  sfr_shifter #(
    .CMD_W (CMD_W),
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_fall_i(sclk_fall),
    .cs_fall_i  (cs_fall),
    .cs_act_i   (cs_act),
    .sdi_i      (pins_s.sdi),
    .cmd_o      (cmd_o),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .cnt_o      (bit_cnt)
  );
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  localparam int FRAME_W = CMD_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [CMD_W-1:0]  cmd,
  input logic [DATA_W-1:0] data,
  input logic              cs_act,
  input logic              cs_fall,
  input logic [CNT_W-1:0]  cnt
);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(cmd) && $stable(data)));

  // R5
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(cs_act));

  // R4
  count_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cnt == CNT_W'(FRAME_W)));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (cnt == '0));
endmodule

bind spi_frame_rx sfr_chk #(
  .CMD_W (CMD_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .valid  (valid_o),
  .cmd    (cmd_o),
  .data   (data_o),
  .cs_act (cs_act),
  .cs_fall(cs_fall),
  .cnt    (bit_cnt)
);

// File: tb/spi_frame_rx_test.sv
module spi_frame_rx_test;
  logic        clk, rst_n, sclk, csn, sdi;
  logic [7:0]  cmd_o;
  logic [15:0] data_o;
  logic        valid_o;

  int n_chk, n_fail, n_pulse, cycles;

  // behavioural model state
  int   m_valid, m_cmd, m_data, m_armed, m_cnt, m_bits;
  logic h1_s, h1_c, h1_d, h2_s, h2_c, h2_d, h3_s, h3_c;

  spi_frame_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(csn), .sdi_i(sdi),
    .cmd_o(cmd_o), .data_o(data_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Model: pins as seen after the synchroniser and edge register
  always @(posedge clk) begin
    if (!rst_n) begin
      {h1_s, h2_s, h3_s} = 3'b000;
      {h1_c, h2_c, h3_c} = 3'b111;
      {h1_d, h2_d}       = 2'b00;
      m_valid = 0; m_cmd = 0; m_data = 0; m_armed = 0; m_cnt = 0; m_bits = 0;
    end else begin
      m_valid = 0;
      if (h2_c) m_armed = 0;
      else if (h3_c && !h2_c) begin
        m_armed = 1; m_cnt = 0; m_bits = 0;
      end else if (m_armed != 0 && h3_s && !h2_s) begin
        m_bits = (m_bits << 1) | int'(h2_d);
        m_cnt++;
        if (m_cnt == 24) begin
          m_armed = 0; m_valid = 1;
          m_cmd  = (m_bits >> 16) & 'hFF;
          m_data = m_bits & 'hFFFF;
        end
      end
      h3_s = h2_s; h3_c = h2_c;
      h2_s = h1_s; h2_c = h1_c; h2_d = h1_d;
      h1_s = sclk; h1_c = csn; h1_d = sdi;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(valid_o == m_valid[0], "R3 strobe vs model", valid_o, m_valid);
      check(cmd_o == m_cmd[7:0], "R2 cmd vs model", cmd_o, m_cmd);
      check(data_o == m_data[15:0], "R8 data vs model", data_o, m_data);
      if (valid_o) n_pulse++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pattern bits are sent from bit 63 downwards
  task automatic send(input logic [63:0] pat, input int nclk);
    csn = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b1; sdi = pat[63-i];
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(2);
      sdi = ~sdi;            // DIN moves while SCLK is low: must not matter
      wait_clk(2);
    end
    wait_clk(4);
    csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic expect_frame(input string req, input int pulses_before,
                              input int exp_pulses, input logic [7:0] c, input logic [15:0] d);
    check(n_pulse - pulses_before == exp_pulses, req, n_pulse - pulses_before, exp_pulses);
    check(cmd_o == c, req, cmd_o, c);
    check(data_o == d, req, data_o, d);
  endtask

  initial begin
    int p;
    n_chk = 0; n_fail = 0; n_pulse = 0; cycles = 0;
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
    wait_clk(5);
    // R1 reset state
    check(valid_o == 1'b0, "R1 valid in reset", valid_o, 0);
    check(cmd_o == 8'h00, "R1 cmd in reset", cmd_o, 0);
    check(data_o == 16'h0000, "R1 data in reset", data_o, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R2 / R3: plain frames
    p = n_pulse; send({8'hA5, 16'h1234, 40'h0}, 24);
    expect_frame("R2 frame A5/1234", p, 1, 8'hA5, 16'h1234);
    p = n_pulse; send({8'h3C, 16'hFFFF, 40'h0}, 24);
    expect_frame("R3 frame 3C/FFFF", p, 1, 8'h3C, 16'hFFFF);
    p = n_pulse; send({8'h00, 16'h0001, 40'h0}, 24);
    expect_frame("R2 frame 00/0001", p, 1, 8'h00, 16'h0001);

    // R4: long frame, trailing bits ignored
    p = n_pulse; send({8'h81, 16'hBEEF, 40'hFF_FFFF_FFFF}, 34);
    expect_frame("R4 long frame", p, 1, 8'h81, 16'hBEEF);

    // R5: short frame discarded
    p = n_pulse; send({8'hFF, 16'h5555, 40'h0}, 20);
    expect_frame("R5 short frame", p, 0, 8'h81, 16'hBEEF);

    // R6: SCLK activity with select high
    p = n_pulse;
    for (int i = 0; i < 9; i++) begin
      sclk = 1'b1; sdi = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    check(n_pulse == p, "R6 clocks with select high", n_pulse - p, 0);
    send({8'h42, 16'h0F0F, 40'h0}, 24);
    expect_frame("R6 frame after idle clocks", p, 1, 8'h42, 16'h0F0F);

    // R7: partial frame then fresh frame
    p = n_pulse;
    send({8'hFF, 16'hFFFF, 40'h0}, 11);
    send({8'h17, 16'hC3A0, 40'h0}, 24);
    expect_frame("R7 restart after partial", p, 1, 8'h17, 16'hC3A0);

    // R8: outputs hold over a long idle
    wait_clk(50);
    check(cmd_o == 8'h17 && data_o == 16'hC3A0, "R8 hold over idle", {cmd_o, data_o}, 24'h17C3A0);

    wait_clk(5);
    finish_run();
  end
endmodule